// File: doc/BRIEF.md
# Quadrant-scanned flag bus controller

This block presents per-queue almost-full flags on a narrow shared status bus. A wide flag vector of 128 queues is split into four quadrants of 32 flags. One quadrant at a time goes onto the bus, timed by the write clock. Flag generation is done elsewhere. This block only chooses which quadrant is shown and when this device may drive the bus.

While reset is held, two pins are captured: the operating style and the master/slave role.

- **Polled style:** quadrants are scanned in a fixed rotation. The scan is carried by a token that passes along a chain of devices. A sync output marks the cycle in which this device shows its first quadrant. A token output pulses while the fourth quadrant is shown. A device that sees the token at a clock edge starts its own scan on that edge. For a single device, the token output is wired back to the token input, and the scan then repeats forever.
- **Direct style:** a strobe samples the write address, and its two low bits pick the quadrant to show. The strobe is ignored until the programming-done input is high.

Top module: `flag_scan_ctrl`

## Requirements
- R1: While reset is low, the following outputs are all 0: bus enable, sync, token-out and the flag bus.
- R2: The style pin (1 = polled, 0 = direct) and the master pin (1 = master) are captured only while reset is low. Changing either pin after reset has no effect on the output sequence.
- R3: A polled master puts quadrant 0 (flags[31:0]) on the bus at the first clock edge after reset release. Each following edge shows the next quadrant, up to quadrant 3 (flags[127:96]), with bus enable high throughout. Quadrant k is flags[32k+31:32k].
- R4: In polled style, sync is high exactly in the cycles when this device shows quadrant 0, and low for its other quadrants.
- R5: In polled style, token-out is high exactly in the cycles when this device shows quadrant 3.
- R6: In polled style, token-in high at a clock edge makes quadrant 0 appear from that edge on. With token-out looped back to token-in, quadrant 0 follows quadrant 3 without a gap.
- R7: In polled style, a device that does not hold the token keeps bus enable low and the flag bus at 0. This holds for a slave after reset, and for any device after its quadrant 3 when no token arrives.
- R8: In direct style, a clock edge with strobe and programming-done both high selects the quadrant given by write address bits [1:0]. The upper address bits are ignored. The selection holds until the next accepted strobe.
- R9: In direct style, a strobe at an edge where programming-done is low leaves the displayed quadrant unchanged.
- R10: In direct style, sync and token-out stay low. A direct-style slave keeps bus enable low and the bus at 0, whatever its strobe or token-in inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low reset; style and role are captured while it is low |
| style_pin_i | input | 1 | 1 = polled scan, 0 = direct selection |
| master_pin_i | input | 1 | 1 = this device is the master |
| strobe_i | input | 1 | Direct-style quadrant select strobe |
| wr_addr_i | input | 8 | Write address; bits [1:0] give the quadrant |
| prog_done_i | input | 1 | High once device programming is complete |
| token_in_i | input | 1 | Scan token from the previous device |
| flags_i | input | 128 | Per-queue almost-full flags |
| flag_bus_o | output | 32 | Displayed quadrant; 0 when not enabled |
| bus_en_o | output | 1 | This device drives the flag bus |
| sync_o | output | 1 | Marks this device's quadrant 0 in polled style |
| token_out_o | output | 1 | Token to the next device, high with quadrant 3 |

## Verification
All state changes happen on a rising edge. The bus, enable, sync and token-out are combinational decodes of that state, so each result is due in the cycle that starts at the edge where the stimulus is sampled. Examples are a token arrival, the edge after reset release, or an accepted strobe. The bench drives inputs and samples outputs one time unit after each rising edge. Each check therefore sees exactly one edge's worth of change. It compares against a quadrant slice computed from the requirement formula, never from design state.

// File: rtl/flag_scan_pkg.sv
package flag_scan_pkg;

  typedef enum logic {
    STYLE_DIRECT = 1'b0,
    STYLE_POLLED = 1'b1
  } scan_style_e;

  // Next quadrant in the rotation, wrapping at the quadrant count.
  function automatic int unsigned quad_step(input int unsigned cur, input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

  // Lowest flag index carried by a quadrant of the given lane width.
  function automatic int unsigned quad_base(input int unsigned quad, input int unsigned lane_w);
    return quad * lane_w;
  endfunction

endpackage

// File: rtl/fsc_cfg_latch.sv
module fsc_cfg_latch
  import flag_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        style_pin_i,
  input  logic        master_pin_i,
  output scan_style_e style_o,
  output logic        master_o,
  output logic        run_o
);

  // Pins are followed only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      style_o  <= scan_style_e'(style_pin_i);
      master_o <= master_pin_i;
      run_o    <= 1'b0;
    end else begin
      run_o    <= 1'b1;
    end
  end

endmodule

// File: rtl/fsc_poll_seq.sv
module fsc_poll_seq
  import flag_scan_pkg::*;
#(
  parameter int QUADS = 4,
  localparam int QW = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          master_i,
  input  logic          token_in_i,
  output logic          active_o,
  output logic [QW-1:0] quad_o,
  output logic          first_o,
  output logic          last_o
);

  logic kick_q;
  logic start_w;

  assign start_w = token_in_i || (kick_q && master_i);
  assign first_o = active_o && (quad_o == '0);
  assign last_o  = active_o && (quad_o == QW'(QUADS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      quad_o   <= '0;
      kick_q   <= 1'b1;
    end else if (enable_i) begin
      kick_q <= 1'b0;
      if (start_w) begin
        active_o <= 1'b1;
        quad_o   <= '0;
      end else if (active_o && !last_o) begin
        quad_o <= QW'(quad_step(int'(quad_o), QUADS));
      end else begin
        active_o <= 1'b0;
        quad_o   <= '0;
      end
    end
  end

endmodule

// File: rtl/fsc_direct_sel.sv
module fsc_direct_sel #(
  parameter int ADDR_W = 8,
  parameter int QUADS  = 4,
  localparam int QW = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              strobe_i,
  input  logic              prog_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              accept_o,
  output logic [QW-1:0]     quad_o
);

  assign accept_o = enable_i && strobe_i && prog_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quad_o <= '0;
    end else if (accept_o) begin
      quad_o <= addr_i[QW-1:0];
    end
  end

endmodule

// File: rtl/fsc_lane_mux.sv
module fsc_lane_mux
  import flag_scan_pkg::*;
#(
  parameter int NUM_Q = 128,
  parameter int QUADS = 4,
  localparam int LANE_W = NUM_Q / QUADS,
  localparam int QW = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic [NUM_Q-1:0]  flags_i,
  input  logic [QW-1:0]     sel_i,
  input  logic              en_i,
  output logic [LANE_W-1:0] bus_o
);

  logic [LANE_W-1:0] lane_w [QUADS];

  for (genvar g = 0; g < QUADS; g++) begin : g_lane
    assign lane_w[g] = flags_i[quad_base(g, LANE_W) +: LANE_W];
  end

  always_comb begin
    bus_o = '0;
    if (en_i) begin
      for (int k = 0; k < QUADS; k++) begin
        if (sel_i == QW'(k)) bus_o = lane_w[k];
      end
    end
  end

endmodule

// File: rtl/flag_scan_ctrl.sv
module flag_scan_ctrl
  import flag_scan_pkg::*;
#(
  parameter int NUM_Q  = 128,
  parameter int QUADS  = 4,
  parameter int ADDR_W = 8,
  localparam int LANE_W = NUM_Q / QUADS,
  localparam int QW = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style_pin_i,
  input  logic              master_pin_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              prog_done_i,
  input  logic              token_in_i,
  input  logic [NUM_Q-1:0]  flags_i,
  output logic [LANE_W-1:0] flag_bus_o,
  output logic              bus_en_o,
  output logic              sync_o,
  output logic              token_out_o
);

  scan_style_e       style_q;
  logic              master_q;
  logic              run_q;
  logic              polled_w;
  logic              poll_active_w;
  logic [QW-1:0]     poll_quad_w;
  logic              poll_first_w;
  logic              poll_last_w;
  logic              dir_accept_w;
  logic [QW-1:0]     dir_quad_w;
  logic [QW-1:0]     cur_quad_w;

  fsc_cfg_latch u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .style_pin_i  (style_pin_i),
    .master_pin_i (master_pin_i),
    .style_o      (style_q),
    .master_o     (master_q),
    .run_o        (run_q)
  );

  assign polled_w = (style_q == STYLE_POLLED);

  fsc_poll_seq #(.QUADS(QUADS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (polled_w),
    .master_i   (master_q),
    .token_in_i (token_in_i),
    .active_o   (poll_active_w),
    .quad_o     (poll_quad_w),
    .first_o    (poll_first_w),
    .last_o     (poll_last_w)
  );

  fsc_direct_sel #(.ADDR_W(ADDR_W), .QUADS(QUADS)) u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (!polled_w),
    .strobe_i    (strobe_i),
    .prog_done_i (prog_done_i),
    .addr_i      (wr_addr_i),
    .accept_o    (dir_accept_w),
    .quad_o      (dir_quad_w)
  );

  assign cur_quad_w  = polled_w ? poll_quad_w : dir_quad_w;
  assign bus_en_o    = rst_n && (polled_w ? poll_active_w : (run_q && master_q));
  assign sync_o      = rst_n && polled_w && poll_first_w;
  assign token_out_o = rst_n && polled_w && poll_last_w;

  fsc_lane_mux #(.NUM_Q(NUM_Q), .QUADS(QUADS)) u_mux (
    .flags_i (flags_i),
    .sel_i   (cur_quad_w),
    .en_i    (bus_en_o),
    .bus_o   (flag_bus_o)
  );

endmodule

// File: rtl/flag_scan_chk.sv
module flag_scan_chk #(
  parameter int QUADS  = 4,
  parameter int LANE_W = 32,
  localparam int QW = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              polled,
  input logic              token_in,
  input logic              prog_done,
  input logic              style_bit,
  input logic              dir_accept,
  input logic [QW-1:0]     cur_quad,
  input logic [QW-1:0]     dir_quad,
  input logic [LANE_W-1:0] flag_bus,
  input logic              bus_en,
  input logic              sync,
  input logic              token_out
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!bus_en && !sync && !token_out && flag_bus == '0));

  p_style_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(style_bit));

  p_poll_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (polled && bus_en && !token_in && cur_quad != QW'(QUADS - 1))
      |=> (bus_en && cur_quad == QW'($past(cur_quad) + 1'b1)));

  p_sync_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (bus_en && cur_quad == '0));

  p_token_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> (bus_en && cur_quad == QW'(QUADS - 1)));

  p_token_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (polled && token_in) |=> sync);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> (flag_bus == '0));

  p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!polled && !prog_done) |=> $stable(dir_quad));

  p_gate_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dir_accept |-> prog_done);

  p_direct_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !polled |-> (!sync && !token_out));

endmodule

bind flag_scan_ctrl flag_scan_chk #(.QUADS(QUADS), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .polled     (polled_w),
  .token_in   (token_in_i),
  .prog_done  (prog_done_i),
  .style_bit  (style_q),
  .dir_accept (dir_accept_w),
  .cur_quad   (cur_quad_w),
  .dir_quad   (dir_quad_w),
  .flag_bus   (flag_bus_o),
  .bus_en     (bus_en_o),
  .sync       (sync_o),
  .token_out  (token_out_o)
);

// File: tb/flag_scan_ctrl_tb.sv
module flag_scan_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 128;
  localparam int LW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          style_pin = 1'b1;
  logic          master_pin = 1'b1;
  logic          strobe = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic          prog_done = 1'b0;
  logic          tok_drv = 1'b0;
  logic          loop_en = 1'b0;
  logic          token_in;
  logic [NQ-1:0] flags;
  logic [LW-1:0] flag_bus;
  logic          bus_en, sync, token_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign token_in = loop_en ? token_out : tok_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_scan_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .style_pin_i  (style_pin),
    .master_pin_i (master_pin),
    .strobe_i     (strobe),
    .wr_addr_i    (wr_addr),
    .prog_done_i  (prog_done),
    .token_in_i   (token_in),
    .flags_i      (flags),
    .flag_bus_o   (flag_bus),
    .bus_en_o     (bus_en),
    .sync_o       (sync),
    .token_out_o  (token_out)
  );

  function automatic logic [LW-1:0] lane(input int k);
    return flags[k*LW +: LW];
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Shown quadrant k (or -1 for idle) with expected sync and token-out.
  task automatic expect_view(input string req, input int k);
    chk(req, "bus_en", 32'(bus_en), (k >= 0) ? 32'd1 : 32'd0);
    chk(req, "flag_bus", flag_bus, (k >= 0) ? lane(k) : '0);
    chk("R4", "sync", 32'(sync), (k == 0) ? 32'd1 : 32'd0);
    chk("R5", "token_out", 32'(token_out), (k == 3) ? 32'd1 : 32'd0);
  endtask

  task automatic do_reset(input logic sty, input logic mst, input logic loop);
    @(posedge clk); #1;
    rst_n = 1'b0; style_pin = sty; master_pin = mst; loop_en = loop;
    tok_drv = 1'b0; strobe = 1'b0; prog_done = 1'b0; wr_addr = '0;
    tick(); tick();
    chk("R1", "bus_en in reset", 32'(bus_en), 32'd0);
    chk("R1", "sync in reset", 32'(sync), 32'd0);
    chk("R1", "token_out in reset", 32'(token_out), 32'd0);
    chk("R1", "bus in reset", flag_bus, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_poll_loop();
    do_reset(1'b1, 1'b1, 1'b1);
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 4; k++) begin
        tick();
        expect_view((r == 0) ? "R3" : "R6", k);
      end
    end
  endtask

  task automatic t_poll_open();
    do_reset(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      tick();
      expect_view("R3", k);
    end
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_view("R7", -1);
    end
  endtask

  task automatic t_poll_slave();
    do_reset(1'b1, 1'b0, 1'b0);
    tick(); tick();
    expect_view("R7", -1);
    tok_drv = 1'b1;
    tick();
    tok_drv = 1'b0;
    expect_view("R6", 0);
    for (int k = 1; k < 4; k++) begin
      tick();
      expect_view("R6", k);
    end
    tick();
    expect_view("R7", -1);
  endtask

  task automatic t_style_frozen();
    do_reset(1'b1, 1'b1, 1'b1);
    tick();
    style_pin = 1'b0; master_pin = 1'b0;
    strobe = 1'b1; prog_done = 1'b1; wr_addr = 8'd2;
    for (int i = 1; i < 9; i++) begin
      tick();
      expect_view("R2", i % 4);
    end
    strobe = 1'b0;
  endtask

  task automatic t_direct_master();
    do_reset(1'b0, 1'b1, 1'b0);
    tick();
    chk("R8", "bus_en after release", 32'(bus_en), 32'd1);
    chk("R8", "initial quadrant", flag_bus, lane(0));
    strobe = 1'b1; wr_addr = 8'd2; prog_done = 1'b0;
    tick();
    chk("R9", "strobe before programming", flag_bus, lane(0));
    prog_done = 1'b1;
    tick();
    chk("R8", "strobe addr 2", flag_bus, lane(2));
    strobe = 1'b0; wr_addr = 8'd1;
    tick();
    chk("R8", "hold without strobe", flag_bus, lane(2));
    tok_drv = 1'b1;
    strobe = 1'b1; wr_addr = 8'h83;
    tick();
    tok_drv = 1'b0; strobe = 1'b0;
    chk("R8", "low bits of addr 0x83", flag_bus, lane(3));
    chk("R10", "sync direct", 32'(sync), 32'd0);
    chk("R10", "token_out direct", 32'(token_out), 32'd0);
  endtask

  task automatic t_direct_slave();
    do_reset(1'b0, 1'b0, 1'b0);
    tick();
    strobe = 1'b1; prog_done = 1'b1; wr_addr = 8'd1; tok_drv = 1'b1;
    tick(); tick();
    strobe = 1'b0; tok_drv = 1'b0;
    chk("R10", "slave bus_en", 32'(bus_en), 32'd0);
    chk("R10", "slave bus", flag_bus, '0);
    chk("R10", "slave sync", 32'(sync), 32'd0);
    chk("R10", "slave token_out", 32'(token_out), 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int q = 0; q < 4; q++) begin
      flags[q*LW +: LW] = (32'h1111_0101 * (q + 1)) ^ 32'hA5C3_0000;
    end
    t_poll_loop();
    t_poll_open();
    t_poll_slave();
    t_style_frozen();
    t_direct_master();
    t_direct_slave();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule